// File: doc/BRIEF.md
# Two-bit up/down counter with prioritized controls

This block is a two-bit Moore counter that holds a present state and presents it unchanged on its output. On every rising clock edge it does exactly one of four things: clear to zero, keep its value, step up by one or step down by one, all modulo four. Which of these happens is settled by three plain control pins with a fixed precedence: the active-low synchronous clear beats the active-low enable, and the enable beats the direction select.

The next-state path is split in two. A small decoder turns the three control pins into one of four operation codes. A four-way selector then picks the next state from clear, hold, increment and decrement. A separate state register holds the result. The block has no data stream, so it has no valid/ready handshake. Every pin is a level-sensitive control or status signal, sampled only at the rising clock edge.

Top module: `udc_counter`

## Requirements
- R1: When `clr_n_i` is 0 at a rising edge, `count_o` is 00 after that edge, whatever `en_n_i` and `dir_i` are.
- R2: When `clr_n_i` is 1 and `en_n_i` is 1 at a rising edge, `count_o` keeps its value across that edge, whatever `dir_i` is.
- R3: When `clr_n_i` is 1, `en_n_i` is 0 and `dir_i` is 0 at a rising edge, `count_o` steps up by one modulo four (00, 01, 10, 11, then 00).
- R4: When `clr_n_i` is 1, `en_n_i` is 0 and `dir_i` is 1 at a rising edge, `count_o` steps down by one modulo four (00, 11, 10, 01, then 00).
- R5: `count_o` is the present state alone. Changes on `clr_n_i`, `en_n_i` or `dir_i` between rising edges leave `count_o` unchanged until the next rising edge.
- R6: All eight combinations of the three control pins give a defined next state, following the order clear, then enable, then direction. A clear followed by one up step gives 01, and a clear followed by one down step gives 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes happen on its rising edge |
| clr_n_i | input | 1 | Synchronous clear, active low, highest precedence |
| en_n_i | input | 1 | Count enable, active low; 1 holds the state |
| dir_i | input | 1 | Direction select: 0 counts up, 1 counts down |
| count_o | output | 2 | Present count, equal to the state register |

## Verification
Clear and counting can be requested in the same cycle. So can hold and a direction change. Both cases are provoked by a sweep that drives every one of the eight control combinations against every reachable state, including clear together with an active enable in both directions. Each case is judged by a behavioural model in the bench, which applies the precedence clear over enable over direction and is compared with `count_o` after every edge. A further test moves the control pins between edges, to show that `count_o` does not follow them until the edge.

// File: rtl/udc_pkg.sv
package udc_pkg;
  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_HOLD  = 2'd1,
    OP_UP    = 2'd2,
    OP_DOWN  = 2'd3
  } udc_op_e;
endpackage

// File: rtl/udc_op_decode.sv
module udc_op_decode
  import udc_pkg::*;
(
  input  logic    clr_n_i,
  input  logic    en_n_i,
  input  logic    dir_i,
  output udc_op_e op_o
);
  // Fixed precedence: clear, then enable, then direction.
  always_comb begin
    if (!clr_n_i)     op_o = OP_CLEAR;
    else if (en_n_i)  op_o = OP_HOLD;
    else if (!dir_i)  op_o = OP_UP;
    else              op_o = OP_DOWN;
  end
endmodule

// File: rtl/udc_next_sel.sv
module udc_next_sel
  import udc_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  udc_op_e        op_i,
  input  logic [W-1:0]   cur_i,
  output logic [W-1:0]   nxt_o
);
  localparam logic [W-1:0] STEP = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] inc_val;
  logic [W-1:0] dec_val;

  assign inc_val = cur_i + STEP;
  assign dec_val = cur_i - STEP;

  // Four-way selection of the next state.
  always_comb begin
    unique case (op_i)
      OP_CLEAR: nxt_o = ZERO;
      OP_HOLD:  nxt_o = cur_i;
      OP_UP:    nxt_o = inc_val;
      OP_DOWN:  nxt_o = dec_val;
      default:  nxt_o = ZERO;
    endcase
  end
endmodule

// File: rtl/udc_state_reg.sv
module udc_state_reg #(
  parameter int W = udc_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    q_o <= d_i;
  end
endmodule

// File: rtl/udc_counter.sv
module udc_counter
  import udc_pkg::*;
(
  input  logic             clk_i,
  input  logic             clr_n_i,
  input  logic             en_n_i,
  input  logic             dir_i,
  output logic [CNT_W-1:0] count_o
);
  udc_op_e          op;
  logic [CNT_W-1:0] state_q;
  logic [CNT_W-1:0] state_d;

  udc_op_decode u_dec (
    .clr_n_i (clr_n_i),
    .en_n_i  (en_n_i),
    .dir_i   (dir_i),
    .op_o    (op)
  );

  udc_next_sel #(.W(CNT_W)) u_sel (
    .op_i  (op),
    .cur_i (state_q),
    .nxt_o (state_d)
  );

  udc_state_reg #(.W(CNT_W)) u_reg (
    .clk_i (clk_i),
    .d_i   (state_d),
    .q_o   (state_q)
  );

  // Moore output: the state itself.
  assign count_o = state_q;

  AST_CLEAR_WINS: assert property (@(posedge clk_i)
    !clr_n_i |=> (count_o == '0)); // R1

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    en_n_i |=> $stable(count_o)); // R2

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (!en_n_i && !dir_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R3

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (!en_n_i && dir_i) |=> (count_o == CNT_W'($past(count_o) - 1'b1))); // R4
endmodule

// File: tb/udc_counter_tb_top.sv
`timescale 1ns/1ps
module udc_counter_tb_top;
  logic       clk_i = 1'b0;
  logic       clr_n_i = 1'b0;
  logic       en_n_i = 1'b1;
  logic       dir_i = 1'b0;
  logic [1:0] count_o;

  int checks = 0;
  int failures = 0;
  int model = 0;

  always #2.5 clk_i = ~clk_i;

  udc_counter dut_i (
    .clk_i   (clk_i),
    .clr_n_i (clr_n_i),
    .en_n_i  (en_n_i),
    .dir_i   (dir_i),
    .count_o (count_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input bit c, input bit e, input bit d);
    if (!c) return "R1";
    if (e) return "R2";
    if (!d) return "R3";
    return "R4";
  endfunction

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input bit c, input bit e, input bit d, input string tag);
    clr_n_i = c; en_n_i = e; dir_i = d;
    @(posedge clk_i);
    if (!c)      model = 0;
    else if (e)  model = model;
    else if (!d) model = (model + 1) % 4;
    else         model = (model + 3) % 4;
    @(negedge clk_i);
    check(tag, int'(count_o), model);
  endtask

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    step(1'b0, 1'b1, 1'b0, "R1");
    check("R1 reset state", int'(count_o), 0);

    // Full up cycle with wrap.
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R3");
    // Full down cycle with wrap.
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, "R4");
    // Hold with direction toggling.
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'(i), "R2");

    // Clear wins against active counting in both directions.
    step(1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, "R6");
    check("R6 clear then up", int'(count_o), 1);
    step(1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b1, "R1");
    step(1'b1, 1'b0, 1'b1, "R6");
    check("R6 clear then down", int'(count_o), 3);

    // R6: every control combination against every reachable state.
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        step(1'b0, 1'b1, 1'b0, "R6");
        for (int j = 0; j < s; j++) step(1'b1, 1'b0, 1'b0, "R6");
        step(1'(k >> 2), 1'(k >> 1), 1'(k), tag_of(1'(k >> 2), 1'(k >> 1), 1'(k)));
      end
    end

    // R5: inputs wiggle between edges, output waits for the edge.
    step(1'b1, 1'b0, 1'b0, "R3");
    clr_n_i = 1'b0; #0.5;
    check("R5 mid-cycle clear", int'(count_o), model);
    clr_n_i = 1'b1; en_n_i = 1'b0; dir_i = 1'b1; #0.5;
    check("R5 mid-cycle down", int'(count_o), model);
    dir_i = 1'b0; #0.5;
    check("R5 mid-cycle up", int'(count_o), model);
    en_n_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R5 hold after wiggle", int'(count_o), model);

    // Mixed pseudo-random pattern.
    for (int i = 0; i < 300; i++) begin
      bit c, e, d;
      c = ((i * 7 + 3) % 11) != 0;
      e = ((i * 5 + 1) % 3) == 0;
      d = ((i * 13) % 7) > 3;
      step(c, e, d, tag_of(c, e, d));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule